// File: doc/BRIEF.md
# Falling-Edge DMA Request Acceptance Controller

This block sits between an external peripheral and the bus arbiter. It accepts transfer requests from the peripheral on an active-low request pin and drives one DMA channel through a series of single address mode transfers. The pin is treated as falling-edge activated, but no free-running edge detector is used. The edge is split into two level-sampling phases. While acceptance is open, a low sample latches a request. After the bus is granted, the block watches for a high sample before it samples for low again.

Software starts the channel by pulsing the enable strobe with a non-zero transfer count. Each time a request is latched, the block raises a request to the bus arbiter and holds it until a grant arrives. It then waits through a bus-release phase and runs a fixed-length single cycle, during which the active-low acknowledge is driven to the peripheral. When the count is used up, the channel disables itself and pulses a done flag.

Top module: `dma_fe_accept`

## Requirements
- R1: While reset is high and on the first cycle after it, `bus_req` is 0, `dack_n` is 1, `busy` is 0 and `done` is 0.
- R2: An `en_wr` pulse with a non-zero `ld_count` sets `busy` on the next edge. The request pin is first sampled on the edge after that, so `bus_req` cannot rise before the second edge after the strobe.
- R3: When acceptance is open, a low sample of `dreq_n` raises `bus_req`. It stays high for as many cycles as `bus_gnt` stays low.
- R4: A grant sampled while `bus_req` is high drops `bus_req` on that edge. A release phase of `REL_CYC` cycles (default 2) with `dack_n` high then follows before the single cycle.
- R5: Each transfer drives `dack_n` low for exactly `SGL_CYC` consecutive cycles (default 2).
- R6: Acceptance reopens after a single cycle only if `dreq_n` was sampled high during the release phase or the single cycle. If it was not, no new request is raised until a high sample arrives, so a pin held low yields one transfer.
- R7: Every single cycle decrements the transfer count. The single cycle that takes the count to zero is followed by `done` high for exactly one cycle, with `busy` low in that same cycle.
- R8: After completion, activity on `dreq_n` raises no `bus_req` and drives no `dack_n` pulse.
- R9: An `en_wr` pulse while `busy` is high is ignored, and the remaining count is unchanged.
- R10: An `en_wr` pulse with `ld_count` equal to 0 leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en_wr | input | 1 | Channel-enable strobe, one cycle |
| ld_count | input | CNT_W | Transfer count, captured with `en_wr` |
| dreq_n | input | 1 | Peripheral request pin, active low |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| bus_req | output | 1 | Latched request to the bus arbiter |
| dack_n | output | 1 | Transfer acknowledge to the peripheral, active low |
| busy | output | 1 | Channel enabled |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the embedded assertions check the following: the request is held until a grant arrives, a grant drops the request, the acknowledge pulse lasts at least two cycles, `done` is a single-cycle pulse seen only when idle, the idle block is quiet, and the count never underflows. Some behaviours need a whole scenario and can only be shown by the directed tests. These are the one-cycle start-up delay before the first sample, the exact release and acknowledge lengths, the rearm rule when the pin stays low, the strobe being ignored while busy, and the number of transfers before completion.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPEN,
      ST_PEND,
      ST_REL,
      ST_SGL,
      ST_REARM
   } dfe_state_e;
endpackage

// File: rtl/dfe_xfer_count.sv
module dfe_xfer_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             last
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)       cnt <= '0;
      else if (load) cnt <= load_val;
      else if (dec)  cnt <= cnt - ONE;
   end

   assign last = (cnt == ONE);

   AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      dec |-> cnt != '0); // R7
endmodule

// File: rtl/dfe_phase_timer.sv
module dfe_phase_timer #(
   parameter int REL_CYC = 2,
   parameter int SGL_CYC = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic in_rel,
   input  logic in_sgl,
   output logic rel_end,
   output logic sgl_end
);
   localparam int MAXC = (REL_CYC > SGL_CYC) ? REL_CYC : SGL_CYC;
   localparam int TW   = $clog2(MAXC + 1);
   localparam logic [TW-1:0] REL_LAST = TW'(REL_CYC - 1);
   localparam logic [TW-1:0] SGL_LAST = TW'(SGL_CYC - 1);

   logic [TW-1:0] tmr;

   assign rel_end = in_rel && (tmr == REL_LAST);
   assign sgl_end = in_sgl && (tmr == SGL_LAST);

   always_ff @(posedge clk) begin
      if (rst)
         tmr <= '0;
      else if ((in_rel && !rel_end) || (in_sgl && !sgl_end))
         tmr <= tmr + TW'(1);
      else
         tmr <= '0;
   end

   AST_REL_BOUND: assert property (@(posedge clk) disable iff (rst)
      in_rel |-> tmr <= REL_LAST); // R4
   AST_SGL_BOUND: assert property (@(posedge clk) disable iff (rst)
      in_sgl |-> tmr <= SGL_LAST); // R5
endmodule

// File: rtl/dfe_high_track.sv
module dfe_high_track (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic watch,
   input  logic dreq_n,
   output logic hi_now
);
   logic hi_q;

   always_ff @(posedge clk) begin
      if (rst || clr)            hi_q <= 1'b0;
      else if (watch && dreq_n)  hi_q <= 1'b1;
   end

   assign hi_now = hi_q || (watch && dreq_n);

   AST_HIGH_FROM_WATCH: assert property (@(posedge clk) disable iff (rst)
      $rose(hi_q) |-> $past(watch && dreq_n)); // R6
endmodule

// File: rtl/dma_fe_accept.sv
module dma_fe_accept
   import dfe_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int REL_CYC = 2,
   parameter int SGL_CYC = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en_wr,
   input  logic [CNT_W-1:0] ld_count,
   input  logic             dreq_n,
   input  logic             bus_gnt,
   output logic             bus_req,
   output logic             dack_n,
   output logic             busy,
   output logic             done
);
   generate
      if (CNT_W < 1)   begin : g_bad_w   $error("CNT_W must be at least 1");   end
      if (REL_CYC < 2) begin : g_bad_rel $error("REL_CYC must be at least 2"); end
      if (SGL_CYC < 2) begin : g_bad_sgl $error("SGL_CYC must be at least 2"); end
   endgenerate

   dfe_state_e state, state_nx;
   logic rel_end, sgl_end, hi_now, cnt_last;
   logic start, grant_take, xfer_end, done_nx;

   assign start      = (state == ST_IDLE) && en_wr && (ld_count != '0);
   assign grant_take = (state == ST_PEND) && bus_gnt;
   assign xfer_end   = (state == ST_SGL) && sgl_end;
   assign done_nx    = xfer_end && cnt_last;

   dfe_xfer_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .load(start), .load_val(ld_count),
      .dec(xfer_end), .last(cnt_last));

   dfe_phase_timer #(.REL_CYC(REL_CYC), .SGL_CYC(SGL_CYC)) u_tmr (
      .clk(clk), .rst(rst), .in_rel(state == ST_REL), .in_sgl(state == ST_SGL),
      .rel_end(rel_end), .sgl_end(sgl_end));

   dfe_high_track u_hi (
      .clk(clk), .rst(rst), .clr(grant_take),
      .watch((state == ST_REL) || (state == ST_SGL)),
      .dreq_n(dreq_n), .hi_now(hi_now));

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:  if (start)       state_nx = ST_OPEN;
         ST_OPEN:  if (!dreq_n)     state_nx = ST_PEND;
         ST_PEND:  if (bus_gnt)     state_nx = ST_REL;
         ST_REL:   if (rel_end)     state_nx = ST_SGL;
         ST_SGL: begin
            if (sgl_end) begin
               if (cnt_last)    state_nx = ST_IDLE;
               else if (hi_now) state_nx = ST_OPEN;
               else             state_nx = ST_REARM;
            end
         end
         ST_REARM: if (dreq_n)      state_nx = ST_OPEN;
         default:                   state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_IDLE;
         done  <= 1'b0;
      end else begin
         state <= state_nx;
         done  <= done_nx;
      end
   end

   assign bus_req = (state == ST_PEND);
   assign dack_n  = (state != ST_SGL);
   assign busy    = (state != ST_IDLE);

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
      bus_req && !bus_gnt |=> bus_req); // R3
   AST_GNT_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
      bus_req && bus_gnt |=> !bus_req && dack_n); // R4
   AST_DACK_MIN_LEN: assert property (@(posedge clk) disable iff (rst)
      !dack_n && $past(dack_n) |=> !dack_n); // R5
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R7
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !busy |-> dack_n && !bus_req); // R8
   AST_ZERO_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !busy && en_wr && ld_count == '0 |=> !busy); // R10
endmodule

// File: tb/sim_dma_fe_accept.sv
`timescale 1ns/1ps
module sim_dma_fe_accept;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en_wr = 1'b0;
   logic [7:0] ld_count = '0;
   logic       dreq_n = 1'b1;
   logic       bus_gnt = 1'b0;
   logic       bus_req, dack_n, busy, done;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   dma_fe_accept u0 (
      .clk(clk), .rst(rst), .en_wr(en_wr), .ld_count(ld_count),
      .dreq_n(dreq_n), .bus_gnt(bus_gnt), .bus_req(bus_req),
      .dack_n(dack_n), .busy(busy), .done(done));

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic start_ch(input int cnt);
      en_wr = 1'b1; ld_count = 8'(cnt);
      step();
      en_wr = 1'b0;
   endtask

   // Waits for a request, grants it, measures release and acknowledge lengths.
   task automatic do_xfer(input bit raise_after_gnt, output int rel, output int low,
                          output int done_end, output int busy_end);
      int w = 0;
      while (!bus_req && w < 20) begin step(); w++; end
      chk(bus_req == 1'b1, "R3", bus_req, 1);
      bus_gnt = 1'b1;
      if (raise_after_gnt) dreq_n = 1'b1;
      step();
      bus_gnt = 1'b0;
      chk(bus_req == 1'b0, "R4", bus_req, 0);
      rel = 0;
      while (dack_n && rel < 20) begin rel++; step(); end
      low = 0;
      while (!dack_n && low < 20) begin low++; step(); end
      done_end = done;
      busy_end = busy;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      step(); step();
      chk(bus_req == 0 && dack_n == 1 && busy == 0 && done == 0, "R1",
          {bus_req, dack_n, busy, done}, 4'b0100);
      rst = 1'b0;
      step();
      chk(bus_req == 0 && dack_n == 1 && busy == 0 && done == 0, "R1",
          {bus_req, dack_n, busy, done}, 4'b0100);
   endtask

   task automatic t_start_delay();
      int rel, low, de, be;
      dreq_n = 1'b0;
      start_ch(1);
      chk(busy == 1'b1, "R2", busy, 1);
      chk(bus_req == 1'b0, "R2", bus_req, 0);
      step();
      chk(bus_req == 1'b1, "R2", bus_req, 1);
      for (int i = 0; i < 8; i++) step();
      chk(bus_req == 1'b1, "R3", bus_req, 1);
      do_xfer(1, rel, low, de, be);
      chk(rel == 2, "R4", rel, 2);
      chk(low == 2, "R5", low, 2);
      chk(de == 1 && be == 0, "R7", {de[0], be[0]}, 2'b10);
      step();
      chk(done == 1'b0, "R7", done, 0);
      for (int i = 0; i < 8; i++) begin
         dreq_n = i[0];
         step();
         chk(bus_req == 0 && dack_n == 1 && busy == 0, "R8",
             {bus_req, dack_n, busy}, 3'b010);
      end
      dreq_n = 1'b1;
   endtask

   task automatic t_multi();
      int rel, low, de, be;
      dreq_n = 1'b1;
      start_ch(3);
      for (int k = 0; k < 3; k++) begin
         step();
         dreq_n = 1'b0;
         do_xfer(1, rel, low, de, be);
         chk(rel == 2, "R4", rel, 2);
         chk(low == 2, "R5", low, 2);
         if (k < 2) chk(de == 0 && be == 1, "R7", {de[0], be[0]}, 2'b01);
         else       chk(de == 1 && be == 0, "R7", {de[0], be[0]}, 2'b10);
      end
      step();
      chk(done == 1'b0 && busy == 1'b0, "R7", {done, busy}, 0);
   endtask

   task automatic t_held_low();
      int rel, low, de, be;
      int seen = 0;
      dreq_n = 1'b0;
      start_ch(2);
      do_xfer(0, rel, low, de, be);
      chk(low == 2 && de == 0, "R6", low, 2);
      for (int i = 0; i < 10; i++) begin
         if (i == 4) begin en_wr = 1'b1; ld_count = 8'd9; end
         step();
         en_wr = 1'b0;
         if (bus_req) seen++;
      end
      chk(seen == 0 && busy == 1'b1, "R6", seen, 0);
      dreq_n = 1'b1;
      step();
      dreq_n = 1'b0;
      do_xfer(1, rel, low, de, be);
      chk(low == 2, "R6", low, 2);
      chk(de == 1 && be == 0, "R9", {de[0], be[0]}, 2'b10);
      dreq_n = 1'b1;
      step();
   endtask

   task automatic t_zero_load();
      dreq_n = 1'b0;
      start_ch(0);
      for (int i = 0; i < 5; i++) begin
         chk(busy == 0 && bus_req == 0, "R10", {busy, bus_req}, 0);
         step();
      end
      dreq_n = 1'b1;
   endtask

   initial begin
      t_reset();
      t_start_delay();
      t_multi();
      t_held_low();
      t_zero_load();
      summary();
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
   end
endmodule